// File: doc/BRIEF.md
# Console Teletype I/O Transfer Bridge

This block sits between the I/O-transfer path of a 12-bit minicomputer and a byte-wide serial receiver and transmitter. When the CPU strobes an I/O-transfer instruction, the bridge decodes it. If the instruction names the console keyboard or the console printer, the bridge answers in the same cycle. It can request a skip of the next instruction, write a new accumulator value, or launch a byte into the transmitter.

The bridge keeps one status flag for each device. The keyboard flag means "a character is waiting". The printer flag means "the last character has gone out". Software polls a flag with a skip instruction and then moves a character. Serial shifting, baud timing and CPU sequencing are handled elsewhere.

An instruction word splits into three fields. Bits 11..9 are the opcode, and 6 marks an I/O transfer. Bits 8..3 are the device code. Bits 2..0 are the function bits: bit 0 means skip on flag, bit 1 means clear, and bit 2 means transfer. Everything the bridge returns is combinational during the strobe cycle. The flags change at the clock edge that ends that cycle.

Top module: `tty_iot_bridge`

## Requirements
- R1: A `rx_valid` pulse captures `rx_byte` into the receive buffer and sets the keyboard flag at the same clock edge.
- R2: Instruction 6031 (octal) under strobe raises `skip_req` exactly when the keyboard flag is set.
- R3: Instruction 6036 asserts `acc_wr` with `acc_wdata` equal to the buffered 8-bit character, with bits 11..8 zero. The keyboard flag is clear after that cycle.
- R4: The keyboard function bits act independently. Bit 1 alone (6032) writes zero and clears the flag. Bit 2 alone (6034) writes `acc_in` ORed with the character and leaves the flag unchanged. Bit 0 combines with either.
- R5: Instruction 6041 raises `skip_req` exactly when the printer flag is set.
- R6: Instruction 6046 pulses `tx_start` for the strobe cycle, with `tx_byte` equal to `acc_in[7:0]`, and clears the printer flag. Bit 2 alone (6044) launches without clearing, and bit 1 alone (6042) clears without launching.
- R7: The printer flag sets at the clock edge after `tx_ready` is first seen high following a low cycle. A skip probe issued in the cycle in which `tx_ready` rises still sees the old flag.
- R8: After reset the printer flag is set, the keyboard flag is clear, and `skip_req`, `acc_wr` and `tx_start` are low.
- R9: Any I/O-transfer instruction whose device code is neither 03 nor 04, and any instruction whose opcode is not 6, gives no skip, no accumulator write and no launch, and leaves both flags unchanged.
- R10: When a byte arrives in the same cycle as a keyboard clear, the flag stays set and the new byte is kept. When `tx_ready` rises in the same cycle as a printer clear, the flag ends up clear.
- R11: With the strobe low, no instruction word produces any output or changes any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iot_strobe | input | 1 | One-cycle I/O transfer strobe |
| instr | input | 12 | Current instruction word |
| acc_in | input | 12 | Current accumulator value |
| rx_byte | input | 8 | Character from the receiver |
| rx_valid | input | 1 | One-cycle pulse: `rx_byte` is valid |
| tx_ready | input | 1 | Transmitter idle level |
| skip_req | output | 1 | Skip the next instruction (strobe cycle only) |
| acc_wr | output | 1 | Write `acc_wdata` into the accumulator |
| acc_wdata | output | 12 | New accumulator value |
| tx_start | output | 1 | Launch `tx_byte` into the transmitter |
| tx_byte | output | 8 | Character to transmit |

## Verification
`skip_req`, `acc_wr`, `acc_wdata`, `tx_start` and `tx_byte` are due in the same cycle as the strobe. The bench drives inputs on the falling edge and samples these outputs 2 ns later, before the next rising edge. Flag effects are due one edge later, so each is read back with a separate skip probe in a later strobe cycle. For the `tx_ready` edge case, the probe is also issued in the rising cycle itself, to confirm the one-edge delay.

// File: rtl/tty_iot_pkg.sv
package tty_iot_pkg;
   localparam int FN_W    = 3;
   localparam int FN_SKIP = 0;
   localparam int FN_CLR  = 1;
   localparam int FN_XFER = 2;

   typedef struct packed {
      logic            hit_kbd;
      logic            hit_tpr;
      logic [FN_W-1:0] fn;
   } iot_dec_t;
endpackage

// File: rtl/tty_iot_decode.sv
module tty_iot_decode
   import tty_iot_pkg::*;
#(
   parameter int WORD_W  = 12,
   parameter int OPC_W   = 3,
   parameter int DEV_W   = 6,
   parameter logic [OPC_W-1:0] OPC_IOT = 3'o6,
   parameter logic [DEV_W-1:0] KBD_DEV = 6'o03,
   parameter logic [DEV_W-1:0] TPR_DEV = 6'o04
) (
   input  logic              iot_strobe,
   input  logic [WORD_W-1:0] instr,
   output iot_dec_t          dec
);
   localparam int OPC_LSB = WORD_W - OPC_W;

   if (OPC_W + DEV_W + FN_W != WORD_W) begin : g_bad_split
      $error("instruction fields do not fill the word");
   end
   if (KBD_DEV == TPR_DEV) begin : g_bad_dev
      $error("device codes must differ");
   end

   logic             is_iot;
   logic [DEV_W-1:0] dev;

   assign is_iot      = iot_strobe && (instr[OPC_LSB +: OPC_W] == OPC_IOT);
   assign dev         = instr[FN_W +: DEV_W];
   assign dec.hit_kbd = is_iot && (dev == KBD_DEV);
   assign dec.hit_tpr = is_iot && (dev == TPR_DEV);
   assign dec.fn      = instr[FN_W-1:0];
endmodule

// File: rtl/tty_kbd_side.sv
module tty_kbd_side
   import tty_iot_pkg::*;
#(
   parameter int WORD_W = 12,
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic [FN_W-1:0]   fn,
   input  logic [WORD_W-1:0] acc_in,
   input  logic [CHAR_W-1:0] rx_byte,
   input  logic              rx_valid,
   output logic              skip,
   output logic              acc_wr,
   output logic [WORD_W-1:0] acc_wdata
);
   if (CHAR_W > WORD_W || CHAR_W < 1) begin : g_bad_char
      $error("character width must fit the word");
   end

   logic              kbd_flag;
   logic [CHAR_W-1:0] rx_buf;
   logic [WORD_W-1:0] char_ext;

   if (CHAR_W < WORD_W) begin : g_pad
      assign char_ext = {{(WORD_W-CHAR_W){1'b0}}, rx_buf};
   end else begin : g_full
      assign char_ext = rx_buf;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kbd_flag <= 1'b0;
         rx_buf   <= '0;
      end else begin
         if (rx_valid) begin
            rx_buf   <= rx_byte;
            kbd_flag <= 1'b1;
         end else if (sel && fn[FN_CLR]) begin
            kbd_flag <= 1'b0;
         end
      end
   end

   assign skip      = sel && fn[FN_SKIP] && kbd_flag;
   assign acc_wr    = sel && (fn[FN_CLR] || fn[FN_XFER]);
   assign acc_wdata = (fn[FN_CLR] ? '0 : acc_in) | (fn[FN_XFER] ? char_ext : '0);

   assert_kbd_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> kbd_flag);
   assert_kbd_buf_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> (rx_buf == $past(rx_byte)));
   assert_kbd_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && fn[FN_CLR] && !rx_valid) |=> !kbd_flag);
   assert_kbd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_valid && !(sel && fn[FN_CLR])) |=> $stable(kbd_flag));
endmodule

// File: rtl/tty_tpr_side.sv
module tty_tpr_side
   import tty_iot_pkg::*;
#(
   parameter int   CHAR_W     = 8,
   parameter logic RESET_DONE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic [FN_W-1:0]   fn,
   input  logic [CHAR_W-1:0] chr_in,
   input  logic              tx_ready,
   output logic              skip,
   output logic              tx_start,
   output logic [CHAR_W-1:0] tx_byte
);
   logic tpr_flag;
   logic ready_q;
   logic ready_rise;
   logic clr_req;

   assign ready_rise = tx_ready && !ready_q;
   assign clr_req    = sel && fn[FN_CLR];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tpr_flag <= RESET_DONE;
         ready_q  <= 1'b1;
      end else begin
         ready_q <= tx_ready;
         if (clr_req)         tpr_flag <= 1'b0;
         else if (ready_rise) tpr_flag <= 1'b1;
      end
   end

   assign skip     = sel && fn[FN_SKIP] && tpr_flag;
   assign tx_start = sel && fn[FN_XFER];
   assign tx_byte  = chr_in;

   assert_tpr_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req |=> !tpr_flag);
   assert_tpr_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && !ready_q && !clr_req) |=> tpr_flag);
   assert_tpr_reset_R8: assert property (@(posedge clk)
      $rose(rst_n) |-> (tpr_flag == RESET_DONE));
endmodule

// File: rtl/tty_iot_bridge.sv
module tty_iot_bridge
   import tty_iot_pkg::*;
#(
   parameter int   WORD_W     = 12,
   parameter int   CHAR_W     = 8,
   parameter int   OPC_W      = 3,
   parameter int   DEV_W      = 6,
   parameter logic [OPC_W-1:0] OPC_IOT = 3'o6,
   parameter logic [DEV_W-1:0] KBD_DEV = 6'o03,
   parameter logic [DEV_W-1:0] TPR_DEV = 6'o04,
   parameter logic TPR_RESET_DONE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iot_strobe,
   input  logic [WORD_W-1:0] instr,
   input  logic [WORD_W-1:0] acc_in,
   input  logic [CHAR_W-1:0] rx_byte,
   input  logic              rx_valid,
   input  logic              tx_ready,
   output logic              skip_req,
   output logic              acc_wr,
   output logic [WORD_W-1:0] acc_wdata,
   output logic              tx_start,
   output logic [CHAR_W-1:0] tx_byte
);
   iot_dec_t dec;
   logic     kbd_skip;
   logic     tpr_skip;

   tty_iot_decode #(
      .WORD_W(WORD_W), .OPC_W(OPC_W), .DEV_W(DEV_W),
      .OPC_IOT(OPC_IOT), .KBD_DEV(KBD_DEV), .TPR_DEV(TPR_DEV)
   ) u_dec (
      .iot_strobe(iot_strobe),
      .instr     (instr),
      .dec       (dec)
   );

   tty_kbd_side #(.WORD_W(WORD_W), .CHAR_W(CHAR_W)) u_kbd (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (dec.hit_kbd),
      .fn       (dec.fn),
      .acc_in   (acc_in),
      .rx_byte  (rx_byte),
      .rx_valid (rx_valid),
      .skip     (kbd_skip),
      .acc_wr   (acc_wr),
      .acc_wdata(acc_wdata)
   );

   tty_tpr_side #(.CHAR_W(CHAR_W), .RESET_DONE(TPR_RESET_DONE)) u_tpr (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (dec.hit_tpr),
      .fn      (dec.fn),
      .chr_in  (acc_in[CHAR_W-1:0]),
      .tx_ready(tx_ready),
      .skip    (tpr_skip),
      .tx_start(tx_start),
      .tx_byte (tx_byte)
   );

   assign skip_req = kbd_skip || tpr_skip;

   assert_skip_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      skip_req |-> iot_strobe);
   assert_wr_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      acc_wr |-> iot_strobe);
   assert_tx_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> iot_strobe);
   assert_dev_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (skip_req || acc_wr || tx_start) |->
         (instr[WORD_W-1 -: OPC_W] == OPC_IOT) &&
         ((instr[FN_W +: DEV_W] == KBD_DEV) || (instr[FN_W +: DEV_W] == TPR_DEV)));
endmodule

// File: tb/tty_iot_bridge_test.sv
module tty_iot_bridge_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iot_strobe = 1'b0;
   logic [11:0] instr = '0;
   logic [11:0] acc_in = '0;
   logic [7:0]  rx_byte = '0;
   logic        rx_valid = 1'b0;
   logic        tx_ready = 1'b1;
   logic        skip_req, acc_wr, tx_start;
   logic [11:0] acc_wdata;
   logic [7:0]  tx_byte;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic        s_skip, s_wr, s_tx;
   logic [11:0] s_wd;
   logic [7:0]  s_txb;

   logic       kflag, tflag;
   logic [7:0] kbuf;

   always #10 clk = ~clk;

   tty_iot_bridge uut (
      .clk(clk), .rst_n(rst_n), .iot_strobe(iot_strobe), .instr(instr),
      .acc_in(acc_in), .rx_byte(rx_byte), .rx_valid(rx_valid),
      .tx_ready(tx_ready), .skip_req(skip_req), .acc_wr(acc_wr),
      .acc_wdata(acc_wdata), .tx_start(tx_start), .tx_byte(tx_byte)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic sample();
      #2;
      s_skip = skip_req; s_wr = acc_wr; s_wd = acc_wdata;
      s_tx = tx_start; s_txb = tx_byte;
   endtask

   task automatic iot(input logic [11:0] ins, input logic [11:0] a);
      @(negedge clk);
      instr = ins; acc_in = a; iot_strobe = 1'b1;
      sample();
      @(negedge clk);
      iot_strobe = 1'b0;
   endtask

   task automatic probe_k(input logic exp, input string tag);
      iot(12'o6031, 12'o0);
      check(s_skip, exp, tag);
   endtask

   task automatic probe_t(input logic exp, input string tag);
      iot(12'o6041, 12'o0);
      check(s_skip, exp, tag);
   endtask

   task automatic rx(input logic [7:0] b);
      @(negedge clk);
      rx_byte = b; rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
      kbuf = b; kflag = 1'b1;
   endtask

   task automatic tx_done();
      @(negedge clk); tx_ready = 1'b0;
      @(negedge clk); tx_ready = 1'b1;
      @(negedge clk);
      tflag = 1'b1;
   endtask

   initial begin
      kflag = 1'b0; tflag = 1'b1; kbuf = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      sample();
      check({s_skip, s_wr, s_tx}, 3'b000, "R8 outputs idle after reset");
      probe_t(1'b1, "R8 printer flag set after reset");
      probe_k(1'b0, "R8 keyboard flag clear after reset");

      // R1 / R2 basic receive
      rx(8'hA5);
      probe_k(1'b1, "R1 R2 flag set by received byte");
      iot(12'o6036, 12'o7777);
      check(s_wr, 1'b1, "R3 read asserts acc_wr");
      check(s_wd, 12'h0A5, "R3 read data zero-extended");
      kflag = 1'b0;
      probe_k(1'b0, "R3 flag cleared by read");

      // R2 R3 R4 sweep of keyboard functions
      for (int kf = 0; kf < 2; kf++) begin
         for (int f = 0; f < 8; f++) begin
            logic [7:0]  b;
            logic [11:0] a, ew;
            b = 8'((f * 37 + kf * 101 + 3) & 255);
            a = 12'o5252 ^ 12'(f * 9);
            if (kf == 1) rx(b);
            else begin iot(12'o6032, 12'o0); kflag = 1'b0; end
            iot(12'o6030 | 12'(f), a);
            check(s_skip, 1'((f & 1) != 0) & kflag, "R2 keyboard skip by function");
            check(s_wr, 1'((f & 6) != 0), "R4 keyboard write enable by function");
            ew = (((f & 2) != 0) ? 12'o0 : a) | (((f & 4) != 0) ? {4'h0, kbuf} : 12'o0);
            if ((f & 6) != 0) check(s_wd, ew, "R4 R3 keyboard write data");
            if ((f & 2) != 0) kflag = 1'b0;
            probe_k(kflag, "R4 keyboard flag after function");
         end
      end

      // R5 R6 sweep of printer functions
      for (int tf = 0; tf < 2; tf++) begin
         for (int f = 0; f < 8; f++) begin
            logic [11:0] a;
            a = 12'(f * 211 + tf * 77 + 5);
            if (tf == 1) tx_done();
            else begin iot(12'o6042, 12'o0); tflag = 1'b0; end
            iot(12'o6040 | 12'(f), a);
            check(s_skip, 1'((f & 1) != 0) & tflag, "R5 printer skip by function");
            check(s_tx, 1'((f & 4) != 0), "R6 launch by function");
            if ((f & 4) != 0) check(s_txb, a[7:0], "R6 launched byte");
            if ((f & 2) != 0) tflag = 1'b0;
            probe_t(tflag, "R6 printer flag after function");
         end
      end

      // R7 flag delay on tx_ready rise
      iot(12'o6046, 12'h041);
      @(negedge clk); tx_ready = 1'b0;
      @(negedge clk);
      tx_ready = 1'b1; instr = 12'o6041; iot_strobe = 1'b1;
      sample();
      check(s_skip, 1'b0, "R7 flag not yet set in rising cycle");
      @(negedge clk); iot_strobe = 1'b0;
      probe_t(1'b1, "R7 flag set one edge after rise");

      // R10 keyboard: byte arrives during read
      rx(8'h11);
      @(negedge clk);
      instr = 12'o6036; iot_strobe = 1'b1; rx_byte = 8'h3C; rx_valid = 1'b1;
      sample();
      check(s_wd, 12'h011, "R10 read returns older byte");
      @(negedge clk); iot_strobe = 1'b0; rx_valid = 1'b0;
      probe_k(1'b1, "R10 arrival beats clear");
      iot(12'o6036, 12'o0);
      check(s_wd, 12'h03C, "R10 new byte kept");

      // R10 printer: rise during clear
      @(negedge clk); tx_ready = 1'b0;
      @(negedge clk);
      tx_ready = 1'b1; instr = 12'o6046; acc_in = 12'h0C3; iot_strobe = 1'b1;
      sample();
      check(s_tx, 1'b1, "R10 launch during rise");
      @(negedge clk); iot_strobe = 1'b0;
      probe_t(1'b0, "R10 clear beats rise");

      // R9 other devices and opcodes
      rx(8'h5A);
      tx_done();
      for (int d = 0; d < 64; d++) begin
         if (d == 3 || d == 4) continue;
         for (int f = 0; f < 8; f++) begin
            iot({3'o6, 6'(d), 3'(f)}, 12'o7777);
            check({s_skip, s_wr, s_tx}, 3'b000, "R9 other device silent");
         end
      end
      for (int op = 0; op < 8; op++) begin
         if (op == 6) continue;
         iot({3'(op), 6'o03, 3'o7}, 12'o7777);
         check({s_skip, s_wr, s_tx}, 3'b000, "R9 non-IOT keyboard field silent");
         iot({3'(op), 6'o04, 3'o7}, 12'o7777);
         check({s_skip, s_wr, s_tx}, 3'b000, "R9 non-IOT printer field silent");
      end
      probe_k(1'b1, "R9 keyboard flag untouched");
      probe_t(1'b1, "R9 printer flag untouched");
      iot(12'o6034, 12'o0);
      check(s_wd, 12'h05A, "R9 buffer untouched");

      // R11 no strobe
      @(negedge clk);
      instr = 12'o6037; acc_in = 12'o7777; iot_strobe = 1'b0;
      sample();
      check({s_skip, s_wr, s_tx}, 3'b000, "R11 keyboard word without strobe");
      @(negedge clk);
      instr = 12'o6047;
      sample();
      check({s_skip, s_wr, s_tx}, 3'b000, "R11 printer word without strobe");
      @(negedge clk);
      probe_k(1'b1, "R11 keyboard flag kept without strobe");
      probe_t(1'b1, "R11 printer flag kept without strobe");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule